// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects interrupt requests from seven external maskable pins, eight internal sources and one nonmaskable pin. It selects one request by programmable priority and offers a single source code to the processor. Each maskable source has a mask bit and a 3-bit level. An in-service register records the sources being handled, so that lower-priority work cannot break into a handler that is already running. The processor takes an offered request with an acknowledge pulse. It closes the handler with an end-of-interrupt pulse. Configuration arrives as plain input ports; no register bus is modelled.

A small state machine drives the processor handshake. In `IDLE` it waits for something it may offer. Transition `IDLE -> OFFER` happens when a nonmaskable request is pending, or when the processor's enable flag is high and a maskable candidate exists. `OFFER` raises the request line and shows the live winner's code. Transition `OFFER -> IDLE` happens when the offer is withdrawn. Transition `OFFER -> GRANT` happens when the acknowledge arrives while the offer is valid; the winner is latched, its in-service bit is set and its edge request is consumed. `GRANT` lasts one cycle: it strobes the latched code, tells the processor to drop its enable flag and pulses a cascade acknowledge where that applies. Then `GRANT -> IDLE` follows unconditionally.

Two inputs can act as cascade links to an external slave controller, and two inputs can re-enter their own handler (special nesting). Some pins can be borrowed by slave operation or by DMA synchronization, and those pins are then ignored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq`, `vec_strobe`, `ie_drop` and `cas_ack` are low, and no source is pending or in service.
- R2: Source codes are external pin k -> k (0..6), internal line j -> 7+j (7..14) and nonmaskable -> 15. Among eligible sources the lowest `src_lvl` value (bits 3s+2..3s for code s) wins, and ties go to the lower code. A source whose `src_mask` bit is 1 is never offered, but its edge request stays pending.
- R3: Pins 0..4 follow their level while `lvl_trig[k]`=1, so a dropped level withdraws the request. Otherwise, and always for pins 5, 6 and the internal lines, a rising edge latches a request that is held until granted.
- R4: A nonmaskable rising edge is offered ahead of all maskable sources as code 15, regardless of `cpu_ie`, masks or in-service state, and sets no in-service bit.
- R5: `int_ack` while `cpu_irq` is high makes `vec_strobe` and `ie_drop` high for exactly the next cycle, with `irq_vec` holding the code that was offered. The in-service bit of the granted maskable source is then set.
- R6: Maskable sources are offered only while `cpu_ie`=1. While any in-service bit is set, only sources whose level is at most that of the highest-priority in-service source are offered.
- R7: A source whose own in-service bit is set is not offered again.
- R8: With `sfnm_en[k]`=1 (k = 0 or 1), source k is offered even while its own in-service bit is set.
- R9: `eoi_wr` clears the in-service bit of the highest-priority in-service source (lowest level, then lowest code).
- R10: With `casc_en[0]` (or `casc_en[1]`), pin 2 (or pin 3) is ignored. Granting source 0 (or 1) pulses `cas_ack[0]` (or `cas_ack[1]`) in the strobe cycle.
- R11: While `slave_mode`=1, pins 4..6 are ignored and latch nothing.
- R12: `dma_xsync[0]` makes pin 5 ignored and `dma_xsync[1]` makes pin 6 ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req | input | 7 | External maskable request pins |
| int_src | input | 8 | Internal source request lines |
| nmi_req | input | 1 | Nonmaskable request, edge sensitive |
| src_mask | input | 15 | Per-source mask, 1 = blocked |
| src_lvl | input | 45 | Per-source 3-bit priority level, 0 highest |
| lvl_trig | input | 5 | Level-trigger select for pins 0..4 |
| sfnm_en | input | 2 | Special nesting enable for sources 0 and 1 |
| casc_en | input | 2 | Cascade enable for sources 0 and 1 |
| slave_mode | input | 1 | Slave operation, releases pins 4..6 |
| dma_xsync | input | 2 | DMA external sync claims pin 5 / pin 6 |
| cpu_ie | input | 1 | Processor interrupt-enable flag |
| int_ack | input | 1 | Processor acknowledge |
| eoi_wr | input | 1 | End-of-interrupt pulse |
| cpu_irq | output | 1 | Interrupt request to the processor |
| irq_vec | output | 4 | Offered or granted source code |
| vec_strobe | output | 1 | Granted code valid, one cycle |
| ie_drop | output | 1 | Processor should clear its enable flag |
| cas_ack | output | 2 | Cascade acknowledge outputs |

## Verification
Arbitration is tried with simultaneous edges on sources of different levels, on equal levels and on masked low-level sources. These cases separate level ordering, code tie-breaking and mask handling. Nesting is tried with equal and lower levels injected over a live handler, plus a re-trigger of that handler's own source with and without special nesting. After one end-of-interrupt, the source offered next shows which in-service bit was cleared. Borrowed pins are driven while cascade, slave or DMA claims are active and again after release, which shows that they are ignored and not latched. Seeded random bursts over all fifteen edge sources with random masks and levels are drained and compared against a bench priority model.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    // pins 0..4 may be level triggered
    localparam int IN_LVL_CNT = 5;
    // pins rerouted by cascade links 0 and 1
    localparam int CAS_PIN0 = 2;
    localparam int CAS_PIN1 = 3;
    // pins released in slave operation
    localparam int SLV_LO = 4;
    localparam int SLV_HI = 6;
    // pins claimed by DMA external sync
    localparam int DMA_PIN0 = 5;
    localparam int DMA_PIN1 = 6;
    // sources that accept special nesting / cascade
    localparam int NEST_CNT = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_GRANT = 2'd2
    } pic_state_e;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N     = 15,
    parameter int LVL_W = 3,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]       elig,
    input  logic [N*LVL_W-1:0] lvl_flat,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);

    logic [LVL_W-1:0] best;

    // lowest level wins; strict compare keeps the lower index on ties
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '1;
        for (int s = 0; s < N; s++) begin
            if (elig[s] && (!valid || lvl_flat[s*LVL_W +: LVL_W] < best)) begin
                valid = 1'b1;
                idx   = IDX_W'(s);
                best  = lvl_flat[s*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] lvl_mode,
    input  logic [N-1:0] avail,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                req[g]    <= 1'b0;
            end else begin
                prev_q[g] <= raw[g];
                if (lvl_mode[g]) begin
                    req[g] <= raw[g] & avail[g];
                end else if (!avail[g]) begin
                    req[g] <= 1'b0;
                end else if (raw[g] && !prev_q[g]) begin
                    req[g] <= 1'b1;
                end else if (clr[g]) begin
                    req[g] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_EXT = 7,
    parameter int N_INT = 8,
    parameter int LVL_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_EXT-1:0]               ext_req,
    input  logic [N_INT-1:0]               int_src,
    input  logic                           nmi_req,
    input  logic [N_EXT+N_INT-1:0]         src_mask,
    input  logic [(N_EXT+N_INT)*LVL_W-1:0] src_lvl,
    input  logic [IN_LVL_CNT-1:0]          lvl_trig,
    input  logic [NEST_CNT-1:0]            sfnm_en,
    input  logic [NEST_CNT-1:0]            casc_en,
    input  logic                           slave_mode,
    input  logic [1:0]                     dma_xsync,
    input  logic                           cpu_ie,
    input  logic                           int_ack,
    input  logic                           eoi_wr,
    output logic                           cpu_irq,
    output logic [$clog2(N_EXT+N_INT+1)-1:0] irq_vec,
    output logic                           vec_strobe,
    output logic                           ie_drop,
    output logic [NEST_CNT-1:0]            cas_ack
);

    localparam int N_SRC  = N_EXT + N_INT;
    localparam int IDX_W  = $clog2(N_SRC);
    localparam int CODE_W = $clog2(N_SRC + 1);
    localparam logic [CODE_W-1:0] NMI_CODE = CODE_W'(N_SRC);

    logic [N_SRC-1:0] raw, avail, lvl_mode, req, clr_req;
    logic [N_SRC-1:0] isr_q, isr_n, cand, reentry;
    logic [LVL_W-1:0] lvl_a [N_SRC];
    logic [LVL_W-1:0] top_lvl;
    logic             isr_any, win_any;
    logic [IDX_W-1:0] isr_idx, win_idx;
    logic             nmi_prev, nmi_pend;
    logic             offer_ok, take;
    logic [CODE_W-1:0] live_code, grant_code;
    logic             grant_nmi;
    pic_state_e       state_q, state_n;

    assign raw      = {int_src, ext_req};
    assign lvl_mode = {{(N_SRC-IN_LVL_CNT){1'b0}}, lvl_trig};
    assign reentry  = {{(N_SRC-NEST_CNT){1'b0}}, sfnm_en};

    for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
        assign lvl_a[g] = src_lvl[g*LVL_W +: LVL_W];
    end

    // pins borrowed by other functions
    always_comb begin
        avail = '1;
        if (casc_en[0]) avail[CAS_PIN0] = 1'b0;
        if (casc_en[1]) avail[CAS_PIN1] = 1'b0;
        if (slave_mode) avail[SLV_HI:SLV_LO] = '0;
        if (dma_xsync[0]) avail[DMA_PIN0] = 1'b0;
        if (dma_xsync[1]) avail[DMA_PIN1] = 1'b0;
    end

    irq_req_capture #(.N(N_SRC)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (raw),
        .lvl_mode (lvl_mode),
        .avail    (avail),
        .clr      (clr_req),
        .req      (req)
    );

    // highest-priority source currently in service
    irq_pick #(.N(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_isr_pick (
        .elig     (isr_q),
        .lvl_flat (src_lvl),
        .valid    (isr_any),
        .idx      (isr_idx)
    );

    always_comb begin
        top_lvl = '1;
        for (int s = 0; s < N_SRC; s++) begin
            if (isr_idx == IDX_W'(s)) top_lvl = lvl_a[s];
        end
    end

    always_comb begin
        for (int s = 0; s < N_SRC; s++) begin
            cand[s] = req[s] & ~src_mask[s]
                    & (~isr_q[s] | reentry[s])
                    & (~isr_any | (lvl_a[s] <= top_lvl));
        end
    end

    irq_pick #(.N(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_win_pick (
        .elig     (cand),
        .lvl_flat (src_lvl),
        .valid    (win_any),
        .idx      (win_idx)
    );

    assign offer_ok  = nmi_pend | (cpu_ie & win_any);
    assign take      = (state_q == ST_OFFER) & offer_ok & int_ack;
    assign live_code = nmi_pend ? NMI_CODE : CODE_W'(win_idx);

    always_comb begin
        clr_req = '0;
        if (take && !nmi_pend) clr_req[win_idx] = 1'b1;
    end

    always_comb begin
        isr_n = isr_q;
        if (eoi_wr && isr_any) isr_n[isr_idx] = 1'b0;
        if (take && !nmi_pend) isr_n[win_idx] = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (offer_ok) state_n = ST_OFFER;
            ST_OFFER: begin
                if (!offer_ok)    state_n = ST_IDLE;
                else if (int_ack) state_n = ST_GRANT;
            end
            ST_GRANT: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // grant data, in-service and nonmaskable latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q      <= '0;
            nmi_prev   <= 1'b0;
            nmi_pend   <= 1'b0;
            grant_code <= '0;
            grant_nmi  <= 1'b0;
        end else begin
            isr_q    <= isr_n;
            nmi_prev <= nmi_req;
            if (nmi_req && !nmi_prev) nmi_pend <= 1'b1;
            else if (take && nmi_pend) nmi_pend <= 1'b0;
            if (take) begin
                grant_code <= live_code;
                grant_nmi  <= nmi_pend;
            end
        end
    end

    // outputs
    always_comb begin
        cpu_irq    = 1'b0;
        irq_vec    = '0;
        vec_strobe = 1'b0;
        ie_drop    = 1'b0;
        cas_ack    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OFFER: begin
                cpu_irq = offer_ok;
                irq_vec = offer_ok ? live_code : '0;
            end
            ST_GRANT: begin
                irq_vec    = grant_code;
                vec_strobe = 1'b1;
                ie_drop    = 1'b1;
                for (int k = 0; k < NEST_CNT; k++) begin
                    cas_ack[k] = casc_en[k] & ~grant_nmi & (grant_code == CODE_W'(k));
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
    parameter int N_SRC  = 15,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_irq,
    input logic              int_ack,
    input logic              cpu_ie,
    input logic              eoi_wr,
    input logic              vec_strobe,
    input logic              ie_drop,
    input logic [CODE_W-1:0] irq_vec,
    input logic [1:0]        cas_ack,
    input logic [1:0]        casc_en,
    input logic [N_SRC-1:0]  isr_q
);

    localparam logic [CODE_W-1:0] NMI_CODE = CODE_W'(N_SRC);

    assert_strobe_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && int_ack) |=> (vec_strobe && ie_drop && irq_vec == $past(irq_vec)));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_strobe |=> !vec_strobe);

    assert_isr_grows_on_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(isr_q) > $countones($past(isr_q))) |-> $past(cpu_irq && int_ack));

    assert_only_nmi_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !cpu_ie) |-> (irq_vec == NMI_CODE));

    assert_eoi_clears_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !(cpu_irq && int_ack) && (isr_q != '0))
            |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

    assert_cas_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cas_ack));

    assert_cas0_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cas_ack[0] |-> (vec_strobe && casc_en[0] && irq_vec == CODE_W'(0)));

    assert_cas1_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cas_ack[1] |-> (vec_strobe && casc_en[1] && irq_vec == CODE_W'(1)));

endmodule

bind prio_irq_ctrl prio_irq_chk #(.N_SRC(N_SRC), .CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_irq    (cpu_irq),
    .int_ack    (int_ack),
    .cpu_ie     (cpu_ie),
    .eoi_wr     (eoi_wr),
    .vec_strobe (vec_strobe),
    .ie_drop    (ie_drop),
    .irq_vec    (irq_vec),
    .cas_ack    (cas_ack),
    .casc_en    (casc_en),
    .isr_q      (isr_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

    localparam int N_EXT = 7;
    localparam int N_INT = 8;
    localparam int N_SRC = 15;
    localparam int LVL_W = 3;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [N_EXT-1:0]       ext_req;
    logic [N_INT-1:0]       int_src;
    logic                   nmi_req;
    logic [N_SRC-1:0]       src_mask;
    logic [N_SRC*LVL_W-1:0] src_lvl;
    logic [4:0]             lvl_trig;
    logic [1:0]             sfnm_en, casc_en, dma_xsync;
    logic                   slave_mode, cpu_ie, int_ack, eoi_wr;
    logic                   cpu_irq, vec_strobe, ie_drop;
    logic [3:0]             irq_vec;
    logic [1:0]             cas_ack;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_src(int_src),
        .nmi_req(nmi_req), .src_mask(src_mask), .src_lvl(src_lvl),
        .lvl_trig(lvl_trig), .sfnm_en(sfnm_en), .casc_en(casc_en),
        .slave_mode(slave_mode), .dma_xsync(dma_xsync), .cpu_ie(cpu_ie),
        .int_ack(int_ack), .eoi_wr(eoi_wr), .cpu_irq(cpu_irq),
        .irq_vec(irq_vec), .vec_strobe(vec_strobe), .ie_drop(ie_drop),
        .cas_ack(cas_ack)
    );

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic set_lvl(int code, int v);
        src_lvl[code*LVL_W +: LVL_W] = LVL_W'(v);
    endtask

    task automatic pulse_src(int code);
        if (code < N_EXT) ext_req[code] = 1'b1;
        else int_src[code-N_EXT] = 1'b1;
        step(1);
        if (code < N_EXT) ext_req[code] = 1'b0;
        else int_src[code-N_EXT] = 1'b0;
    endtask

    task automatic expect_irq(string tag, int code);
        step(3);
        check_eq({tag, " irq"}, cpu_irq, 1);
        check_eq({tag, " vec"}, irq_vec, code);
    endtask

    task automatic expect_quiet(string tag);
        step(3);
        check_eq({tag, " quiet"}, cpu_irq, 0);
    endtask

    task automatic do_ack(string tag, int code, int cas);
        int_ack = 1'b1;
        step(1);
        int_ack = 1'b0;
        cpu_ie  = 1'b0;
        check_eq({tag, " strobe"}, vec_strobe, 1);
        check_eq({tag, " granted"}, irq_vec, code);
        check_eq({tag, " ie_drop"}, ie_drop, 1);
        check_eq({tag, " cas_ack"}, cas_ack, cas);
        step(1);
        check_eq({tag, " strobe single"}, vec_strobe, 0);
    endtask

    task automatic do_eoi();
        eoi_wr = 1'b1;
        step(1);
        eoi_wr = 1'b0;
        cpu_ie = 1'b1;
    endtask

    task automatic serve(string tag, int code);
        expect_irq(tag, code);
        do_ack(tag, code, 0);
        do_eoi();
    endtask

    function automatic int model_pick(logic [N_SRC-1:0] p, logic [N_SRC-1:0] m,
                                      logic [N_SRC*LVL_W-1:0] lv);
        int best = -1;
        int bl = 1 << LVL_W;
        for (int s = 0; s < N_SRC; s++) begin
            if (p[s] && !m[s] && int'(lv[s*LVL_W +: LVL_W]) < bl) begin
                best = s;
                bl = int'(lv[s*LVL_W +: LVL_W]);
            end
        end
        return best;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N_SRC-1:0] pend;
        logic [N_SRC-1:0] r;
        int pick;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        rst_n = 1'b0; ext_req = '0; int_src = '0; nmi_req = 1'b0;
        src_mask = '0; src_lvl = '1; lvl_trig = '0; sfnm_en = '0;
        casc_en = '0; slave_mode = 1'b0; dma_xsync = '0;
        cpu_ie = 1'b0; int_ack = 1'b0; eoi_wr = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        check_eq("R1 irq", cpu_irq, 0);
        check_eq("R1 strobe", vec_strobe, 0);
        check_eq("R1 ie_drop", ie_drop, 0);
        check_eq("R1 cas_ack", cas_ack, 0);
        cpu_ie = 1'b1;
        expect_quiet("R1 nothing pending");

        // R2 level order
        set_lvl(0, 5); set_lvl(9, 2);
        ext_req[0] = 1'b1; int_src[2] = 1'b1;
        step(1);
        ext_req[0] = 1'b0; int_src[2] = 1'b0;
        serve("R2 lower level first", 9);
        serve("R2 remaining", 0);
        // R2 tie on code
        set_lvl(3, 4); set_lvl(10, 4);
        ext_req[3] = 1'b1; int_src[3] = 1'b1;
        step(1);
        ext_req[3] = 1'b0; int_src[3] = 1'b0;
        serve("R2 tie lower code", 3);
        serve("R2 tie second", 10);
        // R2 mask
        set_lvl(8, 0); set_lvl(12, 6);
        src_mask[8] = 1'b1;
        int_src[1] = 1'b1; int_src[5] = 1'b1;
        step(1);
        int_src[1] = 1'b0; int_src[5] = 1'b0;
        serve("R2 masked skipped", 12);
        expect_quiet("R2 masked not offered");
        src_mask[8] = 1'b0;
        serve("R2 unmasked pending kept", 8);

        // R3 level and edge
        src_lvl = '1;
        lvl_trig[1] = 1'b1;
        ext_req[1] = 1'b1;
        expect_irq("R3 level held", 1);
        ext_req[1] = 1'b0;
        expect_quiet("R3 level withdrawn");
        lvl_trig[1] = 1'b0;
        pulse_src(1);
        serve("R3 edge latched", 1);
        pulse_src(6);
        serve("R3 pin6 edge", 6);

        // R4 nonmaskable
        cpu_ie = 1'b0;
        src_mask = '1;
        nmi_req = 1'b1;
        step(1);
        nmi_req = 1'b0;
        expect_irq("R4 nmi with ie off", 15);
        do_ack("R4 nmi grant", 15, 0);
        expect_quiet("R4 nmi consumed");
        src_mask = '0;
        cpu_ie = 1'b1;

        // R6 R7 R8 R9 nesting
        set_lvl(0, 3); set_lvl(8, 3); set_lvl(11, 5);
        pulse_src(0);
        expect_irq("R6 first handler", 0);
        do_ack("R6 first handler", 0, 0);
        cpu_ie = 1'b1;
        pulse_src(11);
        expect_quiet("R6 lower level blocked");
        pulse_src(8);
        expect_irq("R6 equal level preempts", 8);
        do_ack("R6 equal level preempts", 8, 0);
        cpu_ie = 1'b1;
        pulse_src(0);
        expect_quiet("R7 own in-service blocks");
        sfnm_en[0] = 1'b1;
        expect_irq("R8 special nesting", 0);
        do_ack("R8 special nesting", 0, 0);
        sfnm_en[0] = 1'b0;
        do_eoi();
        pulse_src(0);
        expect_irq("R9 eoi cleared source 0", 0);
        do_ack("R9 reentry", 0, 0);
        do_eoi();
        do_eoi();
        serve("R9 all cleared lower level runs", 11);
        cpu_ie = 1'b0;
        pulse_src(7);
        expect_quiet("R6 ie off blocks");
        cpu_ie = 1'b1;
        serve("R6 ie on", 7);

        // R10 cascade
        src_lvl = '1;
        casc_en[0] = 1'b1;
        set_lvl(2, 0);
        ext_req[2] = 1'b1;
        expect_quiet("R10 pin2 ignored");
        ext_req[2] = 1'b0;
        pulse_src(0);
        expect_irq("R10 cascade source", 0);
        do_ack("R10 cascade ack", 0, 1);
        do_eoi();
        casc_en[0] = 1'b0;
        casc_en[1] = 1'b1;
        pulse_src(1);
        expect_irq("R10 cascade source1", 1);
        do_ack("R10 cascade ack1", 1, 2);
        do_eoi();
        casc_en[1] = 1'b0;
        expect_quiet("R10 pin2 not latched");

        // R11 slave mode
        slave_mode = 1'b1;
        pulse_src(4);
        expect_quiet("R11 pin4 ignored");
        slave_mode = 1'b0;
        expect_quiet("R11 pin4 not latched");

        // R12 dma claims
        dma_xsync = 2'b11;
        pulse_src(5);
        pulse_src(6);
        expect_quiet("R12 pins 5 6 ignored");
        dma_xsync = 2'b00;
        expect_quiet("R12 not latched");
        pulse_src(5);
        serve("R12 pin5 released", 5);

        // random bursts against model (R2, R3)
        src_lvl = '1;
        pend = '0;
        for (int it = 0; it < 30; it++) begin
            src_mask = N_SRC'($urandom) & N_SRC'($urandom);
            for (int s = 0; s < N_SRC; s++) set_lvl(s, int'($urandom_range(0, 7)));
            if (it == 29) src_mask = '0;
            r = N_SRC'($urandom);
            ext_req = r[N_EXT-1:0];
            int_src = r[N_SRC-1:N_EXT];
            step(1);
            ext_req = '0;
            int_src = '0;
            pend = pend | r;
            for (int g = 0; g < N_SRC + 1; g++) begin
                pick = model_pick(pend, src_mask, src_lvl);
                if (pick >= 0) begin
                    serve("R2 random", pick);
                    pend[pick] = 1'b0;
                end
            end
            expect_quiet("R2 random drained");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule